// File: doc/BRIEF.md
# Intra 4x4 Luma Predictor

This block builds the 4x4 predicted luma block for one sub-block of an intra-coded macroblock. It takes the already reconstructed neighbouring samples, a mode index and neighbour availability flags. It supports all nine directional 4x4 intra modes: vertical, horizontal, DC, two diagonals, and four half-angle directions. The block returns the prediction as four 32-bit rows, one per clock.

A request is made by raising `start_i` while `ready_o` is high. Every input is registered on that edge, so the requester may change the neighbour buses at once. Rows 0 to 3 then appear on four consecutive cycles with `valid_o` high. `row_idx_o` gives the row number. `ready_o` is low for those four cycles and a start seen during them is ignored. The block does no residual addition, mode decision, neighbour fetch or chroma prediction.

Top module: `intra4x4_pred`

## Requirements
- R1: A start seen while ready is high is accepted. On the next cycle valid rises, and it stays high for exactly four cycles. Ready is low during those cycles, and a start seen while ready is low has no effect.
- R2: Rows come out top to bottom with row_idx_o counting 0,1,2,3. Pixel x of a row sits in bits [8x+7:8x] of row_o. Left sample r is left_i[8r+7:8r]. Above sample i is above_i[8i+7:8i], where samples 4..7 lie to the upper right.
- R3: Mode 0 (vertical) outputs above samples 0..3 in every row.
- R4: Mode 1 (horizontal) fills row r with left sample r.
- R5: Mode 2 (DC) with the upper and left flags both set fills all 16 pixels with (sum of above 0..3 + sum of left 0..3 + 4) >> 3.
- R6: Mode 2 with only the upper flag set uses (sum of above 0..3 + 2) >> 2. With only the left flag set it uses (sum of left 0..3 + 2) >> 2. With neither set it uses 128.
- R7: Mode 3 (diagonal down-left) sets pixel (x,y) to the three-tap filter (a+2b+c+2)>>2 over above samples x+y, x+y+1, x+y+2. Pixel (3,3) is filtered over samples 6,7,7. When the upper-right flag is clear, above samples 4..7 are taken as above sample 3.
- R8: Mode 4 (diagonal down-right) applies the three-tap filter along the edge formed by left 3..0, the corner sample and above 0..3. The main diagonal is centred on the corner.
- R9: Mode 5 (vertical-right) gives pixels with 2x-y even and non-negative the two-tap average (a+b+1)>>1 of the above/corner edge. All other pixels are three-tap filtered.
- R10: Mode 6 (horizontal-down) gives pixels with 2y-x even and non-negative the two-tap average of the left/corner edge. All other pixels are three-tap filtered.
- R11: Mode 7 (vertical-left) gives even rows the two-tap average and odd rows the three-tap filter over above samples starting at x+(y>>1). The upper-right substitution of R7 applies.
- R12: Mode 8 (horizontal-up) interpolates upward along the left column. The bottom row and the last two pixels of row 2 equal left sample 3.
- R13: Mode values 9..15 produce a block of 128s, with err_o high on all four rows of that request. err_o is low for valid modes.
- R14: Input changes after acceptance, including a start held high, do not alter the four rows of the accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a prediction |
| mode_i | input | 4 | Prediction mode index |
| avail_up_i | input | 1 | Above neighbours usable |
| avail_left_i | input | 1 | Left neighbours usable |
| avail_upr_i | input | 1 | Upper-right neighbours usable |
| left_i | input | 32 | Left samples 0..3, sample 0 in the low byte |
| above_i | input | 64 | Above samples 0..7, sample 0 in the low byte |
| corner_i | input | 8 | Above-left corner sample |
| ready_o | output | 1 | Block idle, start will be accepted |
| valid_o | output | 1 | row_o holds a predicted row |
| row_idx_o | output | 2 | Index of the row on row_o |
| row_o | output | 32 | Four predicted pixels, pixel 0 in the low byte |
| err_o | output | 1 | Request used an undefined mode |

## Verification
The hardest case to reach is a request that is accepted while its neighbour buses and the start line go on changing during the four output cycles. A register-capture fault shows up only in that case. The stimulus scrambles every input in the cycle after acceptance. It also holds start high across several blocks, with new random neighbours on every cycle, so the start that is accepted falls exactly on the cycle where ready returns. The substitution of the upper-right samples is reached with the upper-right flag clear and random, non-equal values on above samples 4..7. Every DC availability combination is driven with sample values that give distinct results.

// File: rtl/intra4_pkg.sv
// Shared definitions for the 4x4 intra predictor.
// Assumes a fixed 4x4 block; only sample width is parametrised elsewhere.
package intra4_pkg;
    localparam int BLK_DIM  = 4;
    localparam int ROW_IDXW = $clog2(BLK_DIM);

    typedef enum logic [3:0] {
        PM_VERT = 4'd0,
        PM_HOR  = 4'd1,
        PM_DC   = 4'd2,
        PM_DDL  = 4'd3,
        PM_DDR  = 4'd4,
        PM_VR   = 4'd5,
        PM_HD   = 4'd6,
        PM_VL   = 4'd7,
        PM_HU   = 4'd8
    } pred_mode_e;

    localparam logic [3:0] PM_LAST = 4'd8;
endpackage

// File: rtl/intra4_capture.sv
// Request capture: freezes mode, flags and neighbours when a request is
// accepted. Assumes load_i is high only for one cycle per request.
module intra4_capture #(
    parameter int PIX_W = 8,
    localparam int LEFT_W  = intra4_pkg::BLK_DIM * PIX_W,
    localparam int ABOVE_W = 2 * intra4_pkg::BLK_DIM * PIX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [3:0]         mode_i,
    input  logic               up_i,
    input  logic               left_i_ok,
    input  logic               upr_i,
    input  logic [LEFT_W-1:0]  left_i,
    input  logic [ABOVE_W-1:0] above_i,
    input  logic [PIX_W-1:0]   corner_i,
    output logic [3:0]         mode_q,
    output logic               up_q,
    output logic               left_ok_q,
    output logic               upr_q,
    output logic [LEFT_W-1:0]  left_q,
    output logic [ABOVE_W-1:0] above_q,
    output logic [PIX_W-1:0]   corner_q
);
    // Hold the request operands for the whole output burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            up_q      <= 1'b0;
            left_ok_q <= 1'b0;
            upr_q     <= 1'b0;
            left_q    <= '0;
            above_q   <= '0;
            corner_q  <= '0;
        end else if (load_i) begin
            mode_q    <= mode_i;
            up_q      <= up_i;
            left_ok_q <= left_i_ok;
            upr_q     <= upr_i;
            left_q    <= left_i;
            above_q   <= above_i;
            corner_q  <= corner_i;
        end
    end
endmodule

// File: rtl/intra4_sequencer.sv
// Output sequencer: runs one burst of BLK_DIM rows per accepted request.
// Assumes the kernel output is valid in the cycle after load.
module intra4_sequencer #(
    localparam int IW = intra4_pkg::ROW_IDXW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          load_o,
    output logic          busy_o,
    output logic [IW-1:0] row_o
);
    localparam logic [IW-1:0] LAST_ROW = IW'(intra4_pkg::BLK_DIM - 1);

    // Accept only when idle.
    assign load_o = start_i && !busy_o;

    // Count rows of the burst and drop busy after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            row_o  <= '0;
        end else if (load_o) begin
            busy_o <= 1'b1;
            row_o  <= '0;
        end else if (busy_o) begin
            if (row_o == LAST_ROW) begin
                busy_o <= 1'b0;
            end
            row_o <= row_o + IW'(1);
        end
    end
endmodule

// File: rtl/intra4_kernel.sv
// Prediction kernel: purely combinational 4x4 predictor over captured
// neighbours. Assumes neighbours are stable for the burst. Works on one
// linear edge vector (left 3..0, corner, above 0..3) for the angled modes.
module intra4_kernel #(
    parameter int PIX_W = 8,
    localparam int N       = intra4_pkg::BLK_DIM,
    localparam int LEFT_W  = N * PIX_W,
    localparam int ABOVE_W = 2 * N * PIX_W,
    localparam int BLK_W   = N * N * PIX_W,
    localparam int EDGE_N  = 2 * N + 1
) (
    input  logic [3:0]         mode_i,
    input  logic               up_i,
    input  logic               left_ok_i,
    input  logic               upr_i,
    input  logic [LEFT_W-1:0]  left_i,
    input  logic [ABOVE_W-1:0] above_i,
    input  logic [PIX_W-1:0]   corner_i,
    output logic [BLK_W-1:0]   blk_o
);
    import intra4_pkg::*;

    localparam logic [PIX_W-1:0] MID = PIX_W'(1 << (PIX_W - 1));

    logic [PIX_W-1:0] up_s   [2*N];
    logic [PIX_W-1:0] edge_s [EDGE_N];
    logic [PIX_W+1:0] sum_up, sum_left;
    logic [PIX_W+2:0] sum_both;
    logic [PIX_W-1:0] dc_val;

    function automatic logic [PIX_W-1:0] tap3(input logic [PIX_W-1:0] a,
                                              input logic [PIX_W-1:0] b,
                                              input logic [PIX_W-1:0] c);
        logic [PIX_W+1:0] s;
        s = {2'b00, a} + {1'b0, b, 1'b0} + {2'b00, c} + (PIX_W+2)'(2);
        return PIX_W'(s >> 2);
    endfunction

    function automatic logic [PIX_W-1:0] tap2(input logic [PIX_W-1:0] a,
                                              input logic [PIX_W-1:0] b);
        logic [PIX_W:0] s;
        s = {1'b0, a} + {1'b0, b} + (PIX_W+1)'(1);
        return PIX_W'(s >> 1);
    endfunction

    // Above row with upper-right replaced by the last above sample when absent.
    generate
        for (genvar i = 0; i < 2 * N; i++) begin : g_up
            if (i < N) begin : g_near
                assign up_s[i] = above_i[i*PIX_W +: PIX_W];
            end else begin : g_far
                assign up_s[i] = upr_i ? above_i[i*PIX_W +: PIX_W]
                                       : above_i[(N-1)*PIX_W +: PIX_W];
            end
        end
        // Edge vector: index 0..N-1 = left N-1..0, N = corner, N+1.. = above.
        for (genvar k = 0; k < N; k++) begin : g_edge
            assign edge_s[k]       = left_i[(N-1-k)*PIX_W +: PIX_W];
            assign edge_s[N+1+k]   = above_i[k*PIX_W +: PIX_W];
        end
    endgenerate
    assign edge_s[N] = corner_i;

    // DC value with fallback by neighbour availability.
    always_comb begin
        sum_up   = '0;
        sum_left = '0;
        for (int i = 0; i < N; i++) begin
            sum_up   = sum_up   + (PIX_W+2)'(above_i[i*PIX_W +: PIX_W]);
            sum_left = sum_left + (PIX_W+2)'(left_i[i*PIX_W +: PIX_W]);
        end
        sum_both = (PIX_W+3)'(sum_up) + (PIX_W+3)'(sum_left) + (PIX_W+3)'(4);
        case ({up_i, left_ok_i})
            2'b11:   dc_val = PIX_W'(sum_both >> 3);
            2'b10:   dc_val = PIX_W'((sum_up + (PIX_W+2)'(2)) >> 2);
            2'b01:   dc_val = PIX_W'((sum_left + (PIX_W+2)'(2)) >> 2);
            default: dc_val = MID;
        endcase
    end

    // Per-pixel mode selection over the whole block.
    always_comb begin
        for (int y = 0; y < N; y++) begin
            for (int x = 0; x < N; x++) begin
                int z;
                int j;
                logic [PIX_W-1:0] p;
                z = 0;
                j = 0;
                p = MID;
                case (mode_i)
                    PM_VERT: p = up_s[3'(x)];
                    PM_HOR:  p = edge_s[4'(3 - y)];
                    PM_DC:   p = dc_val;
                    PM_DDL: begin
                        if (x == 3 && y == 3)
                            p = tap3(up_s[6], up_s[7], up_s[7]);
                        else
                            p = tap3(up_s[3'(x+y)], up_s[3'(x+y+1)], up_s[3'(x+y+2)]);
                    end
                    PM_DDR: begin
                        j = 4 + x - y;
                        p = tap3(edge_s[4'(j-1)], edge_s[4'(j)], edge_s[4'(j+1)]);
                    end
                    PM_VR: begin
                        z = 2 * x - y;
                        j = x - (y >> 1);
                        if (z >= 0 && (z % 2) == 0)
                            p = tap2(edge_s[4'(4+j)], edge_s[4'(5+j)]);
                        else if (z > 0)
                            p = tap3(edge_s[4'(3+j)], edge_s[4'(4+j)], edge_s[4'(5+j)]);
                        else if (z == -1)
                            p = tap3(edge_s[3], edge_s[4], edge_s[5]);
                        else
                            p = tap3(edge_s[4'(4-y)], edge_s[4'(5-y)], edge_s[4'(6-y)]);
                    end
                    PM_HD: begin
                        z = 2 * y - x;
                        j = y - (x >> 1);
                        if (z >= 0 && (z % 2) == 0)
                            p = tap2(edge_s[4'(4-j)], edge_s[4'(3-j)]);
                        else if (z > 0)
                            p = tap3(edge_s[4'(5-j)], edge_s[4'(4-j)], edge_s[4'(3-j)]);
                        else if (z == -1)
                            p = tap3(edge_s[3], edge_s[4], edge_s[5]);
                        else
                            p = tap3(edge_s[4'(4+x)], edge_s[4'(3+x)], edge_s[4'(2+x)]);
                    end
                    PM_VL: begin
                        j = x + (y >> 1);
                        if ((y % 2) == 0)
                            p = tap2(up_s[3'(j)], up_s[3'(j+1)]);
                        else
                            p = tap3(up_s[3'(j)], up_s[3'(j+1)], up_s[3'(j+2)]);
                    end
                    PM_HU: begin
                        z = x + 2 * y;
                        j = y + (x >> 1);
                        if (z > 5)
                            p = edge_s[0];
                        else if (z == 5)
                            p = tap3(edge_s[1], edge_s[0], edge_s[0]);
                        else if ((z % 2) == 0)
                            p = tap2(edge_s[4'(3-j)], edge_s[4'(2-j)]);
                        else
                            p = tap3(edge_s[4'(3-j)], edge_s[4'(2-j)], edge_s[4'(1-j)]);
                    end
                    default: p = MID;
                endcase
                blk_o[(y*N + x)*PIX_W +: PIX_W] = p;
            end
        end
    end
endmodule

// File: rtl/intra4x4_pred.sv
// Top of the 4x4 intra predictor: capture stage, combinational kernel and
// row sequencer. Assumes the requester honours ready_o; starts while busy
// are dropped.
module intra4x4_pred #(
    parameter int PIX_W = 8,
    localparam int N       = intra4_pkg::BLK_DIM,
    localparam int IW      = intra4_pkg::ROW_IDXW,
    localparam int ROW_W   = N * PIX_W,
    localparam int ABOVE_W = 2 * N * PIX_W,
    localparam int BLK_W   = N * ROW_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [3:0]         mode_i,
    input  logic               avail_up_i,
    input  logic               avail_left_i,
    input  logic               avail_upr_i,
    input  logic [ROW_W-1:0]   left_i,
    input  logic [ABOVE_W-1:0] above_i,
    input  logic [PIX_W-1:0]   corner_i,
    output logic               ready_o,
    output logic               valid_o,
    output logic [IW-1:0]      row_idx_o,
    output logic [ROW_W-1:0]   row_o,
    output logic               err_o
);
    logic               load;
    logic               busy;
    logic [3:0]         mode_q;
    logic               up_q, left_ok_q, upr_q;
    logic [ROW_W-1:0]   left_q;
    logic [ABOVE_W-1:0] above_q;
    logic [PIX_W-1:0]   corner_q;
    logic [BLK_W-1:0]   blk;

    intra4_sequencer u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .busy_o  (busy),
        .row_o   (row_idx_o)
    );

    intra4_capture #(.PIX_W(PIX_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .mode_i    (mode_i),
        .up_i      (avail_up_i),
        .left_i_ok (avail_left_i),
        .upr_i     (avail_upr_i),
        .left_i    (left_i),
        .above_i   (above_i),
        .corner_i  (corner_i),
        .mode_q    (mode_q),
        .up_q      (up_q),
        .left_ok_q (left_ok_q),
        .upr_q     (upr_q),
        .left_q    (left_q),
        .above_q   (above_q),
        .corner_q  (corner_q)
    );

    intra4_kernel #(.PIX_W(PIX_W)) u_kern (
        .mode_i    (mode_q),
        .up_i      (up_q),
        .left_ok_i (left_ok_q),
        .upr_i     (upr_q),
        .left_i    (left_q),
        .above_i   (above_q),
        .corner_i  (corner_q),
        .blk_o     (blk)
    );

    // Present the current row and status.
    assign ready_o = !busy;
    assign valid_o = busy;
    assign row_o   = blk[row_idx_o*ROW_W +: ROW_W];
    assign err_o   = busy && (mode_q > intra4_pkg::PM_LAST);
endmodule

// File: rtl/intra4x4_pred_chk.sv
// Protocol and mode checks for intra4x4_pred, attached by bind.
// Assumes synchronous active-low reset held from time zero.
module intra4x4_pred_chk #(
    parameter int PIX_W = 8,
    localparam int N       = intra4_pkg::BLK_DIM,
    localparam int IW      = intra4_pkg::ROW_IDXW,
    localparam int ROW_W   = N * PIX_W,
    localparam int ABOVE_W = 2 * N * PIX_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               ready_o,
    input logic               valid_o,
    input logic [IW-1:0]      row_idx_o,
    input logic [ROW_W-1:0]   row_o,
    input logic               err_o,
    input logic [3:0]         mode_q,
    input logic [ROW_W-1:0]   left_q,
    input logic [ABOVE_W-1:0] above_q
);
    localparam logic [PIX_W-1:0] MID = PIX_W'(1 << (PIX_W - 1));
    localparam logic [IW-1:0]    LAST_ROW = IW'(N - 1);

    p_first_row_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && ready_o) |=> (valid_o && row_idx_o == '0));

    p_run_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && row_idx_o == LAST_ROW) |=> !valid_o);

    p_row_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && row_idx_o != LAST_ROW) |=>
            (valid_o && row_idx_o == $past(row_idx_o) + IW'(1)));

    p_vert_rows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && mode_q == 4'd0) |-> (row_o == above_q[ROW_W-1:0]));

    p_hu_bottom_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && mode_q == 4'd8 && row_idx_o == LAST_ROW) |->
            (row_o == {N{left_q[ROW_W-1 -: PIX_W]}}));

    p_bad_mode_fill_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && err_o) |-> (row_o == {N{MID}}));

    p_err_steady_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && row_idx_o != '0) |-> $stable(err_o));
endmodule

bind intra4x4_pred intra4x4_pred_chk #(.PIX_W(PIX_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ready_o   (ready_o),
    .valid_o   (valid_o),
    .row_idx_o (row_idx_o),
    .row_o     (row_o),
    .err_o     (err_o),
    .mode_q    (mode_q),
    .left_q    (left_q),
    .above_q   (above_q)
);

// File: tb/intra4x4_pred_tb_top.sv
// Bench: behavioural neighbour-coordinate model, compared every cycle.
module intra4x4_pred_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [3:0]  mode_i;
    logic        avail_up_i, avail_left_i, avail_upr_i;
    logic [31:0] left_i;
    logic [63:0] above_i;
    logic [7:0]  corner_i;
    logic        ready_o, valid_o, err_o;
    logic [1:0]  row_idx_o;
    logic [31:0] row_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;
    string override_tag = "";

    logic [31:0] exp_row[$];
    bit          exp_err[$];
    string       exp_tag[$];

    int ml[4];
    int ma[8];
    int mq;
    bit m_up, m_left, m_upr;

    always #10 clk = ~clk;

    intra4x4_pred dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .avail_up_i(avail_up_i), .avail_left_i(avail_left_i),
        .avail_upr_i(avail_upr_i), .left_i(left_i), .above_i(above_i),
        .corner_i(corner_i), .ready_o(ready_o), .valid_o(valid_o),
        .row_idx_o(row_idx_o), .row_o(row_o), .err_o(err_o)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // neighbour at coordinate (xx,yy) relative to block origin
    function automatic int nb(int xx, int yy);
        if (xx == -1 && yy == -1) return mq;
        if (yy == -1) return (xx > 3 && !m_upr) ? ma[3] : ma[xx];
        return ml[yy];
    endfunction

    function automatic int f3(int a, int b, int c);
        return (a + 2 * b + c + 2) / 4;
    endfunction

    function automatic int f2(int a, int b);
        return (a + b + 1) / 2;
    endfunction

    function automatic int ref_pix(int md, int x, int y);
        int z;
        int sa;
        int sl;
        sa = ma[0] + ma[1] + ma[2] + ma[3];
        sl = ml[0] + ml[1] + ml[2] + ml[3];
        case (md)
            0: return ma[x];
            1: return ml[y];
            2: begin
                if (m_up && m_left) return (sa + sl + 4) / 8;
                if (m_up) return (sa + 2) / 4;
                if (m_left) return (sl + 2) / 4;
                return 128;
            end
            3: begin
                if (x == 3 && y == 3) return f3(nb(6, -1), nb(7, -1), nb(7, -1));
                return f3(nb(x + y, -1), nb(x + y + 1, -1), nb(x + y + 2, -1));
            end
            4: begin
                if (x > y) return f3(nb(x - y - 2, -1), nb(x - y - 1, -1), nb(x - y, -1));
                if (x < y) return f3(nb(-1, y - x - 2), nb(-1, y - x - 1), nb(-1, y - x));
                return f3(nb(0, -1), nb(-1, -1), nb(-1, 0));
            end
            5: begin
                z = 2 * x - y;
                if (z >= 0 && z % 2 == 0)
                    return f2(nb(x - y / 2 - 1, -1), nb(x - y / 2, -1));
                if (z > 0)
                    return f3(nb(x - y / 2 - 2, -1), nb(x - y / 2 - 1, -1), nb(x - y / 2, -1));
                if (z == -1) return f3(nb(-1, 0), nb(-1, -1), nb(0, -1));
                return f3(nb(-1, y - 1), nb(-1, y - 2), nb(-1, y - 3));
            end
            6: begin
                z = 2 * y - x;
                if (z >= 0 && z % 2 == 0)
                    return f2(nb(-1, y - x / 2 - 1), nb(-1, y - x / 2));
                if (z > 0)
                    return f3(nb(-1, y - x / 2 - 2), nb(-1, y - x / 2 - 1), nb(-1, y - x / 2));
                if (z == -1) return f3(nb(-1, 0), nb(-1, -1), nb(0, -1));
                return f3(nb(x - 1, -1), nb(x - 2, -1), nb(x - 3, -1));
            end
            7: begin
                if (y % 2 == 0) return f2(nb(x + y / 2, -1), nb(x + y / 2 + 1, -1));
                return f3(nb(x + y / 2, -1), nb(x + y / 2 + 1, -1), nb(x + y / 2 + 2, -1));
            end
            8: begin
                z = x + 2 * y;
                if (z > 5) return ml[3];
                if (z == 5) return f3(ml[2], ml[3], ml[3]);
                if (z % 2 == 0) return f2(ml[y + x / 2], ml[y + x / 2 + 1]);
                return f3(ml[y + x / 2], ml[y + x / 2 + 1], ml[y + x / 2 + 2]);
            end
            default: return 128;
        endcase
    endfunction

    function automatic string tag_of(int md);
        case (md)
            0: return "R3";
            1: return "R4";
            2: return (m_up && m_left) ? "R5" : "R6";
            3: return "R7";
            4: return "R8";
            5: return "R9";
            6: return "R10";
            7: return "R11";
            8: return "R12";
            default: return "R13";
        endcase
    endfunction

    // Cycle model: compare outputs, retire a row, then accept a new request.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit busy_m;
            busy_m = (exp_row.size() != 0);
            check("R1", "valid_o", 64'(valid_o), 64'(busy_m));
            check("R1", "ready_o", 64'(ready_o), 64'(!busy_m));
            if (busy_m) begin
                check("R2", "row_idx_o", 64'(row_idx_o), 64'(4 - exp_row.size()));
                check(exp_tag[0], "row_o", 64'(row_o), 64'(exp_row[0]));
                check(exp_err[0] ? "R13" : exp_tag[0], "err_o", 64'(err_o), 64'(exp_err[0]));
                void'(exp_row.pop_front());
                void'(exp_err.pop_front());
                void'(exp_tag.pop_front());
            end
            if (start_i && ready_o) begin
                for (int i = 0; i < 4; i++) begin
                    ml[i] = int'(left_i[8*i +: 8]);
                end
                for (int i = 0; i < 8; i++) begin
                    ma[i] = int'(above_i[8*i +: 8]);
                end
                mq = int'(corner_i);
                m_up = avail_up_i;
                m_left = avail_left_i;
                m_upr = avail_upr_i;
                for (int y = 0; y < 4; y++) begin
                    logic [31:0] r;
                    for (int x = 0; x < 4; x++) begin
                        r[8*x +: 8] = 8'(ref_pix(int'(mode_i), x, y));
                    end
                    exp_row.push_back(r);
                    exp_err.push_back(mode_i > 4'd8);
                    exp_tag.push_back(override_tag != "" ? override_tag : tag_of(int'(mode_i)));
                end
            end
        end
    end

    task automatic scramble();
        left_i       = $urandom;
        above_i      = {$urandom, $urandom};
        corner_i     = 8'($urandom);
        mode_i       = 4'($urandom);
        avail_up_i   = 1'($urandom);
        avail_left_i = 1'($urandom);
        avail_upr_i  = 1'($urandom);
    endtask

    task automatic send(input logic [3:0] md, input bit up, input bit lf, input bit ur,
                        input logic [31:0] l, input logic [63:0] a, input logic [7:0] q,
                        input bit mess);
        @(posedge clk); #1;
        mode_i = md; avail_up_i = up; avail_left_i = lf; avail_upr_i = ur;
        left_i = l; above_i = a; corner_i = q; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        if (mess) scramble();
        repeat (4) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0;
        mode_i = '0; avail_up_i = 0; avail_left_i = 0; avail_upr_i = 0;
        left_i = '0; above_i = '0; corner_i = '0;
        repeat (3) @(posedge clk);
        #5;
        // reset state, R1
        check("R1", "reset valid_o", 64'(valid_o), 64'd0);
        check("R1", "reset ready_o", 64'(ready_o), 64'd1);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // Fixed ramps for every mode (R3..R12), R2 packing order.
        for (int md = 0; md < 9; md++) begin
            send(4'(md), 1, 1, 1, 32'h4030_2010, 64'h8878_6858_4838_2818, 8'h05, 0);
            send(4'(md), 1, 1, 0, 32'h0a64_c8ff, 64'h1122_3344_e0c0_a080, 8'hf0, 0);
        end
        // DC availability combinations, R5 and R6.
        for (int av = 0; av < 4; av++) begin
            send(4'd2, av[1], av[0], 1, 32'h0307_0b0f, 64'h0_1f2e_3d4c, 8'h77, 0);
        end
        // Saturating extremes.
        send(4'd2, 1, 1, 1, 32'hffff_ffff, 64'hffff_ffff_ffff_ffff, 8'hff, 0);
        send(4'd4, 1, 1, 1, 32'hffff_ffff, 64'hffff_ffff_ffff_ffff, 8'hff, 0);
        send(4'd8, 1, 1, 1, 32'h0000_0000, 64'h0, 8'h00, 0);
        // Undefined modes, R13.
        send(4'd9, 1, 1, 1, 32'h1234_5678, 64'h9abc_def0_1234_5678, 8'h42, 0);
        send(4'd15, 0, 0, 0, 32'h1234_5678, 64'h9abc_def0_1234_5678, 8'h42, 0);
        // Random neighbours, every mode and flag set.
        for (int n = 0; n < 120; n++) begin
            send(4'(n % 9), 1'($urandom), 1'($urandom), 1'($urandom), $urandom,
                 {$urandom, $urandom}, 8'($urandom), 0);
        end
        // R14: inputs scrambled right after acceptance.
        override_tag = "R14";
        for (int n = 0; n < 30; n++) begin
            send(4'(n % 10), 1'($urandom), 1'($urandom), 1'($urandom), $urandom,
                 {$urandom, $urandom}, 8'($urandom), 1);
        end
        // R14 with R1: start held high, inputs changing every cycle.
        @(posedge clk); #1;
        start_i = 1'b1;
        for (int n = 0; n < 40; n++) begin
            mode_i = 4'($urandom_range(0, 8));
            left_i = $urandom; above_i = {$urandom, $urandom}; corner_i = 8'($urandom);
            avail_up_i = 1'($urandom); avail_left_i = 1'($urandom); avail_upr_i = 1'($urandom);
            @(posedge clk); #1;
        end
        start_i = 1'b0;
        override_tag = "";
        repeat (8) @(posedge clk);
        finish_run();
    end
endmodule